// File: doc/BRIEF.md
# Planar Intra Predictor

This block builds one square predicted block of 8-bit samples for a video intra predictor by planar interpolation. It uses four kinds of neighbouring reference sample: a row of samples above the block, a column to its left, one sample past the top-right corner and one past the bottom-left corner. Every predicted sample is a distance-weighted blend of these four. Block sizes of 4, 8, 16 and 32 are supported.

Software or an upstream stage first fills an internal reference array through a simple write port. It then pulses `start` with a size code. The block streams the prediction out as vectors of up to eight samples, one vector per clock. Each vector carries its row and the column of its first lane. A 4x4 block leaves row by row. Larger blocks leave as 8x8 tiles: eight rows of one tile in order, then the tile to the right, and after the last tile of a band the next band of eight rows starts again at column 0.

Top module: `planar_pred_gen`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` and `done` are low and no vector is produced until a start is accepted.
- R2: For block size nt, the reference array is read as follows: index nt-1 holds the bottom-left sample, index 3*nt+1 the top-right sample, index 2*nt+1+c the top sample of column c, and index 2*nt-1-r the left sample of row r.
- R3: Size code 0,1,2,3 selects nt = 4,8,16,32. Sample (r,c) equals ((r+1)*bottom_left + (c+1)*top_right + (nt-1-r)*top[c] + (nt-1-c)*left[r] + nt) shifted right by log2(nt)+1, and the low 8 bits of that value are kept.
- R4: For nt = 4, four vectors leave with rows 0,1,2,3 in order and `out_col` = 0. Lanes 4..7 are zero.
- R5: For nt >= 8, vectors leave in 8x8 tiles. Rows advance first within a tile, then the column steps by 8, and then the band steps by 8 rows with the column back at 0. `out_col` is always a multiple of 8.
- R6: If `start` is sampled high at clock edge E while the block is idle, the first vector is valid after edge E+2. The remaining vectors follow on consecutive clocks with no gap: 4 vectors for nt = 4 and nt*nt/8 otherwise.
- R7: `done` is high for exactly one cycle, the cycle right after the final vector, and `out_valid` is low in that cycle.
- R8: A `start` pulse while a block is being produced is ignored. The size, order and count of the current block are unchanged.
- R9: A reference write while a block is being produced is ignored. The array keeps its earlier content for the next block.
- R10: Lane i of `out_data` (bits 8*i+7 down to 8*i) holds the sample of column `out_col`+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_we | input | 1 | Reference array write enable |
| ref_addr | input | 8 | Reference array write index (0..128) |
| ref_data | input | 8 | Reference sample to write |
| start | input | 1 | Begin producing a block (accepted only when idle) |
| size_code | input | 2 | Block size select: 0=4, 1=8, 2=16, 3=32 |
| out_valid | output | 1 | Output vector valid |
| out_row | output | 5 | Row of the current vector |
| out_col | output | 5 | Column of lane 0 of the current vector |
| out_data | output | 64 | Eight 8-bit samples, lane 0 in the low byte |
| done | output | 1 | One-cycle pulse after the final vector |

## Verification
The bench pushes every sample to its extremes. All-zero and all-255 references at every size test the 16-bit sum and the size-dependent shift. A wrong shift or a truncated sum would turn an all-255 block into a value other than 255. Random references catch swapped weights or an off-by-one in the left or top index, since the error pattern then shows up along rows or columns. The tile walk is compared vector by vector: a sequencer that wraps the column at the wrong point, or forgets to reset it at a band change, reports a wrong row or column tag. A start pulse and a reference write injected mid-block catch a design that restarts or changes size, or that lets the array change under a running block. Both faults show up as a wrong count, a misplaced `done` or wrong samples in the next block.

// File: rtl/planar_pkg.sv
package planar_pkg;
  localparam int SAMPLE_W  = 8;
  localparam int LANES     = 8;
  localparam int MIN_NT    = 4;
  localparam int MAX_NT    = 32;
  localparam int CODE_W    = 2;
  localparam int COORD_W   = $clog2(MAX_NT);
  localparam int NT_W      = COORD_W + 1;
  localparam int REF_DEPTH = 4 * MAX_NT + 1;
  localparam int ADDR_W    = $clog2(REF_DEPTH);
  localparam int ACC_W     = 16;
  localparam int WT_W      = 8;
  localparam int SHIFT_W   = 3;
  localparam int ROFF_W    = $clog2(LANES);
  localparam int NRD       = LANES + 3;

  // block edge length for a size code
  function automatic logic [NT_W-1:0] nt_from_code(input logic [CODE_W-1:0] code);
    return NT_W'(MIN_NT) << code;
  endfunction
endpackage

// File: rtl/planar_ref_bank.sv
module planar_ref_bank
  import planar_pkg::*;
#(
  parameter int DEPTH = REF_DEPTH,
  parameter int AW    = ADDR_W,
  parameter int DW    = SAMPLE_W,
  parameter int NPORT = NRD
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [NPORT-1:0][AW-1:0]   rd_addr,
  output logic [NPORT-1:0][DW-1:0]   rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // storage has no reset; it is always written before use
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_comb begin
      rd_data[p] = '0;
      if (int'(rd_addr[p]) < DEPTH) rd_data[p] = mem[rd_addr[p]];
    end
  end
endmodule

// File: rtl/planar_tile_seq.sv
module planar_tile_seq
  import planar_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CODE_W-1:0]  size_code,
  output logic               busy,
  output logic [CODE_W-1:0]  run_code,
  output logic [COORD_W-1:0] cur_row,
  output logic [COORD_W-1:0] cur_col,
  output logic               cur_last
);
  logic               busy_q, busy_d;
  logic [CODE_W-1:0]  code_q, code_d;
  logic [COORD_W-1:0] band_q, band_d;
  logic [COORD_W-1:0] col_q, col_d;
  logic [ROFF_W-1:0]  roff_q, roff_d;

  logic [NT_W-1:0]    nt;
  logic [COORD_W-1:0] span;
  logic               narrow, accept, last;

  always_comb begin
    nt     = nt_from_code(code_q);
    span   = COORD_W'(nt - NT_W'(LANES));
    narrow = (code_q == '0);
    accept = start && !busy_q;
    if (narrow) last = (roff_q == ROFF_W'(MIN_NT - 1));
    else        last = (roff_q == '1) && (band_q == span) && (col_q == span);

    busy_d = busy_q;
    code_d = code_q;
    band_d = band_q;
    col_d  = col_q;
    roff_d = roff_q;
    if (accept) begin
      busy_d = 1'b1;
      code_d = size_code;
      band_d = '0;
      col_d  = '0;
      roff_d = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else if (narrow || (roff_q != '1)) begin
        roff_d = roff_q + ROFF_W'(1);
      end else begin
        roff_d = '0;
        if (col_q == span) begin
          col_d  = '0;
          band_d = band_q + COORD_W'(LANES);
        end else begin
          col_d  = col_q + COORD_W'(LANES);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      code_q <= '0;
      band_q <= '0;
      col_q  <= '0;
      roff_q <= '0;
    end else begin
      busy_q <= busy_d;
      code_q <= code_d;
      band_q <= band_d;
      col_q  <= col_d;
      roff_q <= roff_d;
    end
  end

  assign busy     = busy_q;
  assign run_code = code_q;
  assign cur_row  = band_q + COORD_W'(roff_q);
  assign cur_col  = col_q;
  assign cur_last = last;
endmodule

// File: rtl/planar_lane.sv
module planar_lane
  import planar_pkg::*;
(
  input  logic                lane_en,
  input  logic [NT_W-1:0]     nt,
  input  logic [SHIFT_W-1:0]  shift,
  input  logic [COORD_W-1:0]  row,
  input  logic [COORD_W-1:0]  col,
  input  logic [SAMPLE_W-1:0] s_bl,
  input  logic [SAMPLE_W-1:0] s_tr,
  input  logic [SAMPLE_W-1:0] s_top,
  input  logic [SAMPLE_W-1:0] s_left,
  output logic [SAMPLE_W-1:0] sample
);
  logic [WT_W-1:0]  w_down, w_right, w_up, w_left;
  logic [ACC_W-1:0] acc, scaled;

  always_comb begin
    w_down  = WT_W'(row) + WT_W'(1);
    w_right = WT_W'(col) + WT_W'(1);
    w_up    = WT_W'(nt) - WT_W'(1) - WT_W'(row);
    w_left  = WT_W'(nt) - WT_W'(1) - WT_W'(col);
    acc = ACC_W'(w_down)  * ACC_W'(s_bl)
        + ACC_W'(w_right) * ACC_W'(s_tr)
        + ACC_W'(w_up)    * ACC_W'(s_top)
        + ACC_W'(w_left)  * ACC_W'(s_left)
        + ACC_W'(nt);
    scaled = acc >> shift;
    sample = lane_en ? scaled[SAMPLE_W-1:0] : '0;
  end
endmodule

// File: rtl/planar_pred_gen.sv
module planar_pred_gen
  import planar_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ref_we,
  input  logic [ADDR_W-1:0]         ref_addr,
  input  logic [SAMPLE_W-1:0]       ref_data,
  input  logic                      start,
  input  logic [CODE_W-1:0]         size_code,
  output logic                      out_valid,
  output logic [COORD_W-1:0]        out_row,
  output logic [COORD_W-1:0]        out_col,
  output logic [LANES*SAMPLE_W-1:0] out_data,
  output logic                      done
);
  logic               seq_busy, seq_last;
  logic [CODE_W-1:0]  seq_code;
  logic [COORD_W-1:0] seq_row, seq_col;

  planar_tile_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
    .busy(seq_busy), .run_code(seq_code), .cur_row(seq_row),
    .cur_col(seq_col), .cur_last(seq_last)
  );

  logic [NRD-1:0][ADDR_W-1:0]   rd_addr;
  logic [NRD-1:0][SAMPLE_W-1:0] rd_data;
  logic [NT_W-1:0]              nt;
  logic [SHIFT_W-1:0]           shift;

  always_comb begin
    nt         = nt_from_code(seq_code);
    shift      = SHIFT_W'(seq_code) + SHIFT_W'($clog2(MIN_NT) + 1);
    rd_addr[0] = ADDR_W'(nt) - ADDR_W'(1);
    rd_addr[1] = ADDR_W'(3) * ADDR_W'(nt) + ADDR_W'(1);
    rd_addr[2] = ADDR_W'(2) * ADDR_W'(nt) - ADDR_W'(1) - ADDR_W'(seq_row);
    for (int i = 0; i < LANES; i++)
      rd_addr[3+i] = ADDR_W'(2) * ADDR_W'(nt) + ADDR_W'(1) + ADDR_W'(seq_col) + ADDR_W'(i);
  end

  planar_ref_bank u_bank (
    .clk(clk), .wr_en(ref_we && !seq_busy), .wr_addr(ref_addr),
    .wr_data(ref_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [LANES-1:0][SAMPLE_W-1:0] lane_q;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    planar_lane u_lane (
      .lane_en(l < MIN_NT || seq_code != '0),
      .nt(nt), .shift(shift), .row(seq_row),
      .col(seq_col + COORD_W'(l)),
      .s_bl(rd_data[0]), .s_tr(rd_data[1]),
      .s_top(rd_data[3+l]), .s_left(rd_data[2]),
      .sample(lane_q[l])
    );
  end

  logic                           vld_q, vld_d, last_q, last_d, done_q, done_d;
  logic [COORD_W-1:0]             row_q, col_q;
  logic [LANES-1:0][SAMPLE_W-1:0] data_q;
  logic                           cap_en;

  always_comb begin
    cap_en = seq_busy;
    vld_d  = seq_busy;
    last_d = seq_busy && seq_last;
    done_d = vld_q && last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      last_q <= last_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      row_q  <= seq_row;
      col_q  <= seq_col;
      data_q <= lane_q;
    end
  end

  assign out_valid = vld_q;
  assign out_row   = row_q;
  assign out_col   = col_q;
  assign out_data  = data_q;
  assign done      = done_q;
endmodule

// File: rtl/planar_pred_chk.sv
module planar_pred_chk
  import planar_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      busy,
  input logic [CODE_W-1:0]         code,
  input logic                      out_valid,
  input logic [COORD_W-1:0]        out_col,
  input logic [LANES*SAMPLE_W-1:0] out_data,
  input logic                      done
);
  // R6
  first_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> ##1 out_valid);
  // R6
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);
  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && $past(out_valid));
  // R8
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(code));
  // R5
  col_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_col[ROFF_W-1:0] == '0);
  // R4
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && code == '0 |-> out_data[LANES*SAMPLE_W-1:MIN_NT*SAMPLE_W] == '0);
endmodule

bind planar_pred_gen planar_pred_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(seq_busy), .code(seq_code),
  .out_valid(out_valid), .out_col(out_col), .out_data(out_data), .done(done)
);

// File: tb/test_planar_pred_gen.sv
module test_planar_pred_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_we;
  logic [7:0]  ref_addr;
  logic [7:0]  ref_data;
  logic        start;
  logic [1:0]  size_code;
  logic        out_valid;
  logic [4:0]  out_row, out_col;
  logic [63:0] out_data;
  logic        done;

  planar_pred_gen i_planar_pred_gen (
    .clk(clk), .rst_n(rst_n), .ref_we(ref_we), .ref_addr(ref_addr),
    .ref_data(ref_data), .start(start), .size_code(size_code),
    .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
    .out_data(out_data), .done(done)
  );

  always #4 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  int  mirror [129];

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model(int nt, int r, int c);
    int sh = $clog2(nt) + 1;
    int s = (r + 1) * mirror[nt - 1] + (c + 1) * mirror[3 * nt + 1]
          + (nt - 1 - r) * mirror[2 * nt + 1 + c] + (nt - 1 - c) * mirror[2 * nt - 1 - r] + nt;
    return (s >> sh) & 255;
  endfunction

  task automatic write_ref(input int a, input int d);
    @(negedge clk);
    ref_we = 1; ref_addr = 8'(a); ref_data = 8'(d);
    @(negedge clk);
    ref_we = 0;
    mirror[a] = d;
  endtask

  // mode 0: all zero, 1: all 255, 2: random
  task automatic fill(input int mode);
    for (int a = 0; a < 129; a++)
      write_ref(a, mode == 0 ? 0 : mode == 1 ? 255 : int'($urandom_range(0, 255)));
  endtask

  // disturb: inject a start pulse (R8) and a write (R9) mid-block
  task automatic run(input int code, input bit disturb);
    int nt = 4 << code;
    int n  = (nt == 4) ? 4 : nt * nt / 8;
    int per_band = (nt / 8) * 8;
    @(negedge clk);
    start = 1; size_code = 2'(code);
    @(negedge clk);
    start = 0;
    for (int k = 1; k <= n + 3; k++) begin
      if (disturb && k == 3) begin
        start = 1; size_code = 2'((code + 1) % 4);
        ref_we = 1; ref_addr = 8'(2 * nt + 1); ref_data = 8'(~mirror[2 * nt + 1]);
      end
      if (disturb && k == 4) begin
        start = 0; ref_we = 0;
      end
      // R6: valid window, R7: done placement
      check(out_valid == (k >= 2 && k <= n + 1), "R6 out_valid timing", out_valid, (k >= 2 && k <= n + 1));
      check(done == (k == n + 2), "R7 done pulse", done, (k == n + 2));
      if (out_valid && k >= 2 && k <= n + 1) begin
        int i = k - 2;
        int er, ec;
        logic [63:0] ev = '0;
        if (nt == 4) begin
          er = i; ec = 0;
        end else begin
          er = (i / per_band) * 8 + (i % per_band) % 8;
          ec = ((i % per_band) / 8) * 8;
        end
        check(out_row == 5'(er), nt == 4 ? "R4 row order" : "R5 tile row", out_row, er);
        check(out_col == 5'(ec), nt == 4 ? "R4 column" : "R5 tile column", out_col, ec);
        for (int l = 0; l < 8; l++)
          if (nt != 4 || l < 4) ev[8*l +: 8] = 8'(model(nt, er, ec + l));
        // R2 R3 R10: sample values, lane placement, zero upper lanes for nt=4 (R4)
        check(out_data == ev, "R3 samples", out_data, ev);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    rst_n = 0; ref_we = 0; ref_addr = 0; ref_data = 0; start = 0; size_code = 0;
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && !done, "R1 reset state", {out_valid, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!out_valid && !done, "R1 idle after reset", {out_valid, done}, 0);
    for (int mode = 0; mode < 3; mode++) begin
      fill(mode);
      for (int code = 0; code < 4; code++) run(code, 0);
    end
    fill(2);
    run(0, 0);
    run(2, 0);
    // R8 and R9: disturbed run, then the array must still match the mirror
    run(1, 1);
    run(1, 0);
    run(0, 1);
    run(0, 0);
    wrap_up();
  end
endmodule